// File: doc/BRIEF.md
# Two-Wire Bus Master Receiver with Status-Code Sequencing

This block is a byte-level master for a two-wire serial bus (SCL clock, SDA data, both open-drain). It reads bytes from an addressed slave. Software steers it through a small control register and a data register. Each finished bus event is reported as an 8-bit status code, and the interrupt flag is set at the same time. After that the block parks, with SCL held low, until software writes a 0 to the flag. The start, stop and acknowledge-enable bits present at that moment choose what the bus does next. The block therefore has no fixed read sequence: it is a state machine whose state is the status code software sees.

A quarter-period tick, derived from the system clock by a programmable divider, paces a bit engine. The engine makes START, repeated START and STOP conditions and transfers 9-bit frames (eight data bits, MSB first, then an acknowledge bit). It watches for another master pulling SDA low while it has released the line. A bus monitor synchronises the two lines and decides when the bus is free.

Top module: `twi_rx_master`

## Requirements
- R1: After reset, status reads F8h, all four control bits read 0, and neither SCL nor SDA is driven low.
- R2: With status F8h and the start bit (control bit 3) set, the block waits until both lines have been high for BUS_FREE_CYC clocks. It then issues a START, after which status reads 08h and the flag (control bit 1) is set.
- R3: In status 08h or 10h, clearing the flag sends the data register MSB first, with bit 0 as the read/write bit. For a read address (bit 0 = 1), an acknowledging slave gives status 40h and a non-acknowledging one gives 48h.
- R4: In status 40h or 50h, clearing the flag receives one byte MSB first into the data register. With acknowledge-enable (control bit 0) at 1 the block drives ACK and reports 50h. With it at 0 the block leaves SDA released (NACK) and reports 58h.
- R5: In status 48h, 58h, 18h or 20h, clearing the flag with only the start bit set issues a repeated START, giving status 10h.
- R6: In those same states, clearing the flag with only the stop bit (control bit 2) set issues a STOP. Status then reads F8h, the flag stays 0, the stop bit clears itself, and both lines are released.
- R7: Clearing the flag with both start and stop set issues a STOP, then a START once the bus is free, ending in status 08h with the stop bit at 0.
- R8: An address with bit 0 = 0 reports 18h when acknowledged and 20h when not acknowledged.
- R9: The block may release SDA during an address bit or a NACK bit, then sample SDA low while SCL is high. In that case it releases both lines, reports 38h and sets the flag.
- R10: In status 38h, clearing the flag with start at 0 returns the block to idle (F8h). Clearing it with start at 1 also passes through F8h, and a START is then sent when the bus becomes free, giving 08h.
- R11: While the flag is 1 (status not 38h), SCL is held low, no bus action occurs, and status and data stay unchanged. Only a control write with bit 1 = 0 clears the flag; writing 1 to bit 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write: [3] start, [2] stop, [1] flag (0 clears), [0] acknowledge enable |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Address byte to send |
| ctl_rdata | output | 4 | Control register contents, same layout as ctl_wdata |
| dat_rdata | output | 8 | Data register: address loaded or last byte received |
| status | output | 8 | Current status code |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
The bench pairs the block with a behavioural slave that answers one address and streams computed bytes. Reads are run at that address and at a different one, and with the read/write bit both set and clear, so all four address outcomes (40h, 48h, 18h, 20h) are separated. Bytes are received with ACK and with NACK replies, showing that the acknowledge-enable bit alone picks 50h or 58h and that the byte order is MSB first. A rival pull-down on SDA is applied during an address bit and during a NACK bit, with both settings of the start bit afterwards. This tells an immediate return to idle apart from a START that waits for a free bus. A shadow check on every clock confirms that SCL stays low whenever the flag is up.

// File: rtl/twi_rx_pkg.sv
package twi_rx_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = BYTE_W + 1;
  localparam int BIDX_W  = $clog2(FRAME_W);

  localparam logic [7:0] ST_IDLE     = 8'hF8;
  localparam logic [7:0] ST_START    = 8'h08;
  localparam logic [7:0] ST_RSTART   = 8'h10;
  localparam logic [7:0] ST_W_ACK    = 8'h18;
  localparam logic [7:0] ST_W_NACK   = 8'h20;
  localparam logic [7:0] ST_ARB_LOST = 8'h38;
  localparam logic [7:0] ST_R_ACK    = 8'h40;
  localparam logic [7:0] ST_R_NACK   = 8'h48;
  localparam logic [7:0] ST_D_ACK    = 8'h50;
  localparam logic [7:0] ST_D_NACK   = 8'h58;

  typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_XFER} cmd_e;
  typedef enum logic [2:0] {JOB_NONE, JOB_START, JOB_STOP, JOB_ADDR, JOB_DATA} job_e;
endpackage

// File: rtl/twi_qtick.sv
module twi_qtick #(
  parameter int QDIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/twi_busmon.sv
module twi_busmon #(
  parameter int SYNC_STAGES  = 2,
  parameter int BUS_FREE_CYC = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic bus_free
);
  localparam int FW = $clog2(BUS_FREE_CYC + 1);
  localparam logic [FW-1:0] FREE_MAX = FW'(BUS_FREE_CYC);

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic [FW-1:0] free_cnt;
  logic scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      free_cnt <= '0;
      bus_free <= 1'b0;
    end else begin
      if (!(scl_s && sda_s)) free_cnt <= '0;
      else if (free_cnt != FREE_MAX) free_cnt <= free_cnt + 1'b1;
      bus_free <= scl_s && sda_s && (free_cnt == FREE_MAX);
    end
  end
endmodule

// File: rtl/twi_bit_engine.sv
module twi_bit_engine
  import twi_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               sda_s,
  input  logic               go,
  input  cmd_e               cmd,
  input  logic [FRAME_W-1:0] tx_frame,
  input  logic [FRAME_W-1:0] arb_mask,
  output logic               done,
  output logic               lost,
  output logic [FRAME_W-1:0] rx_frame,
  output logic               scl_low,
  output logic               sda_low
);
  typedef enum logic [1:0] {E_IDLE, E_START, E_STOP, E_XFER} est_e;

  est_e               st;
  logic [1:0]         q;
  logic [BIDX_W-1:0]  bi;
  logic [FRAME_W-1:0] tx_q, msk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= E_IDLE;
      q        <= 2'd0;
      bi       <= '0;
      tx_q     <= '1;
      msk_q    <= '0;
      rx_frame <= '0;
      done     <= 1'b0;
      lost     <= 1'b0;
      scl_low  <= 1'b0;
      sda_low  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        E_IDLE: begin
          if (go) begin
            lost  <= 1'b0;
            tx_q  <= tx_frame;
            msk_q <= arb_mask;
            bi    <= BIDX_W'(FRAME_W - 1);
            q     <= 2'd0;
            unique case (cmd)
              CMD_START: begin
                st <= E_START;
                q  <= scl_low ? 2'd0 : 2'd2;
              end
              CMD_STOP: st <= E_STOP;
              default:  st <= E_XFER;
            endcase
          end
        end
        E_START: if (tick) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: sda_low <= 1'b0;
            2'd1: scl_low <= 1'b0;
            2'd2: sda_low <= 1'b1;
            default: begin
              scl_low <= 1'b1;
              st      <= E_IDLE;
              done    <= 1'b1;
            end
          endcase
        end
        E_STOP: if (tick) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: sda_low <= 1'b1;
            2'd1: scl_low <= 1'b0;
            default: begin
              sda_low <= 1'b0;
              st      <= E_IDLE;
              done    <= 1'b1;
            end
          endcase
        end
        default: if (tick) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: sda_low <= ~tx_q[bi];
            2'd1: scl_low <= 1'b0;
            2'd2: begin
              rx_frame[bi] <= sda_s;
              if (msk_q[bi] && tx_q[bi] && !sda_s) begin
                lost    <= 1'b1;
                scl_low <= 1'b0;
                sda_low <= 1'b0;
                st      <= E_IDLE;
                done    <= 1'b1;
              end
            end
            default: begin
              scl_low <= 1'b1;
              if (bi == '0) begin
                st   <= E_IDLE;
                done <= 1'b1;
              end else begin
                bi <= bi - 1'b1;
              end
            end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/twi_rx_ctl.sv
module twi_rx_ctl
  import twi_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_we,
  input  logic [3:0]         ctl_wdata,
  input  logic               dat_we,
  input  logic [BYTE_W-1:0]  dat_wdata,
  input  logic               bus_free,
  input  logic               eng_done,
  input  logic               eng_lost,
  input  logic [FRAME_W-1:0] eng_rx,
  output logic               eng_go,
  output cmd_e               eng_cmd,
  output logic [FRAME_W-1:0] eng_tx,
  output logic [FRAME_W-1:0] eng_mask,
  output logic [3:0]         ctl_rdata,
  output logic [BYTE_W-1:0]  dat_rdata,
  output logic [7:0]         status
);
  logic start_b, stop_b, flag, ack_en, busy, rep;
  job_e job;

  assign ctl_rdata = {start_b, stop_b, flag, ack_en};

  always_ff @(posedge clk) begin
    if (rst) begin
      start_b   <= 1'b0;
      stop_b    <= 1'b0;
      flag      <= 1'b0;
      ack_en    <= 1'b0;
      busy      <= 1'b0;
      rep       <= 1'b0;
      job       <= JOB_NONE;
      status    <= ST_IDLE;
      dat_rdata <= '0;
      eng_go    <= 1'b0;
      eng_cmd   <= CMD_START;
      eng_tx    <= '1;
      eng_mask  <= '0;
    end else begin
      eng_go <= 1'b0;

      if (ctl_we) begin
        start_b <= ctl_wdata[3];
        stop_b  <= ctl_wdata[2];
        ack_en  <= ctl_wdata[0];
        if (!ctl_wdata[1]) flag <= 1'b0;
      end
      if (dat_we) dat_rdata <= dat_wdata;

      if (!busy && !flag) begin
        unique case (status)
          ST_IDLE: if (start_b && bus_free) begin
            eng_go <= 1'b1; eng_cmd <= CMD_START; busy <= 1'b1;
            job <= JOB_START; rep <= 1'b0;
          end
          ST_START, ST_RSTART: begin
            eng_go   <= 1'b1; eng_cmd <= CMD_XFER; busy <= 1'b1;
            eng_tx   <= {dat_rdata, 1'b1};
            eng_mask <= {{BYTE_W{1'b1}}, 1'b0};
            job      <= JOB_ADDR;
          end
          ST_R_ACK, ST_D_ACK: begin
            eng_go   <= 1'b1; eng_cmd <= CMD_XFER; busy <= 1'b1;
            eng_tx   <= {{BYTE_W{1'b1}}, ~ack_en};
            eng_mask <= {{BYTE_W{1'b0}}, 1'b1};
            job      <= JOB_DATA;
          end
          ST_ARB_LOST: status <= ST_IDLE;
          default: begin
            if (stop_b) begin
              eng_go <= 1'b1; eng_cmd <= CMD_STOP; busy <= 1'b1;
              job <= JOB_STOP;
            end else if (start_b) begin
              eng_go <= 1'b1; eng_cmd <= CMD_START; busy <= 1'b1;
              job <= JOB_START; rep <= 1'b1;
            end
          end
        endcase
      end

      if (eng_done) begin
        busy <= 1'b0;
        job  <= JOB_NONE;
        unique case (job)
          JOB_START: begin
            status <= rep ? ST_RSTART : ST_START;
            flag   <= 1'b1;
          end
          JOB_STOP: begin
            status <= ST_IDLE;
            stop_b <= 1'b0;
          end
          JOB_ADDR: begin
            flag <= 1'b1;
            if (eng_lost) status <= ST_ARB_LOST;
            else begin
              unique case ({dat_rdata[0], eng_rx[0]})
                2'b10:   status <= ST_R_ACK;
                2'b11:   status <= ST_R_NACK;
                2'b00:   status <= ST_W_ACK;
                default: status <= ST_W_NACK;
              endcase
            end
          end
          JOB_DATA: begin
            flag <= 1'b1;
            if (eng_lost) status <= ST_ARB_LOST;
            else begin
              dat_rdata <= eng_rx[FRAME_W-1:1];
              status    <= eng_rx[0] ? ST_D_NACK : ST_D_ACK;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_rx_master.sv
module twi_rx_master
  import twi_rx_pkg::*;
#(
  parameter int QDIV         = 8,
  parameter int BUS_FREE_CYC = 32,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [3:0]        ctl_wdata,
  input  logic              dat_we,
  input  logic [BYTE_W-1:0] dat_wdata,
  output logic [3:0]        ctl_rdata,
  output logic [BYTE_W-1:0] dat_rdata,
  output logic [7:0]        status,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low
);
  logic tick, sda_s, bus_free;
  logic eng_go, eng_done, eng_lost;
  cmd_e eng_cmd;
  logic [FRAME_W-1:0] eng_tx, eng_mask, eng_rx;

  twi_qtick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  twi_busmon #(.SYNC_STAGES(SYNC_STAGES), .BUS_FREE_CYC(BUS_FREE_CYC)) u_mon (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .bus_free(bus_free)
  );

  twi_bit_engine u_eng (
    .clk(clk), .rst(rst), .tick(tick), .sda_s(sda_s),
    .go(eng_go), .cmd(eng_cmd), .tx_frame(eng_tx), .arb_mask(eng_mask),
    .done(eng_done), .lost(eng_lost), .rx_frame(eng_rx),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low)
  );

  twi_rx_ctl u_ctl (
    .clk(clk), .rst(rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata),
    .bus_free(bus_free),
    .eng_done(eng_done), .eng_lost(eng_lost), .eng_rx(eng_rx),
    .eng_go(eng_go), .eng_cmd(eng_cmd), .eng_tx(eng_tx), .eng_mask(eng_mask),
    .ctl_rdata(ctl_rdata), .dat_rdata(dat_rdata), .status(status)
  );
endmodule

// File: rtl/twi_rx_master_chk.sv
module twi_rx_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_we,
  input logic       wr_flag_bit,
  input logic       dat_we,
  input logic       flag,
  input logic       stop_bit,
  input logic [7:0] dat_rdata,
  input logic [7:0] status,
  input logic       scl_drive_low,
  input logic       sda_drive_low
);
  AST_FLAG_HOLDS_SCL: assert property (@(posedge clk) disable iff (rst)
    (flag && status != 8'h38) |-> scl_drive_low); // R11

  AST_FLAG_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> ($past(ctl_we) && !$past(wr_flag_bit))); // R11

  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (flag && $past(flag) && !$past(dat_we)) |-> $stable(dat_rdata)); // R11

  AST_LOST_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (status == 8'h38) |-> (!scl_drive_low && !sda_drive_low)); // R9

  AST_STOP_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (status == 8'hF8 && $past(status) != 8'hF8 && $past(status) != 8'h38)
      |-> (!stop_bit && !flag)); // R6
endmodule

bind twi_rx_master twi_rx_master_chk u_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we), .wr_flag_bit(ctl_wdata[1]),
  .dat_we(dat_we), .flag(ctl_rdata[1]), .stop_bit(ctl_rdata[2]),
  .dat_rdata(dat_rdata), .status(status),
  .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
);

// File: tb/tb_twi_rx_master.sv
`timescale 1ns/1ps
module tb_twi_rx_master;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       ctl_we = 1'b0, dat_we = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic [7:0] dat_wdata = '0;
  logic [3:0] ctl_rdata;
  logic [7:0] dat_rdata, status;
  logic       scl_drive_low, sda_drive_low;
  logic       scl_bus, sda_bus;
  logic       sl_drive, rival_low;

  assign scl_bus = !scl_drive_low;
  assign sda_bus = !(sda_drive_low || sl_drive || rival_low);

  twi_rx_master dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .ctl_rdata(ctl_rdata),
    .dat_rdata(dat_rdata), .status(status), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic model_on = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sbyte(input int k);
    logic [7:0] kk = k[7:0];
    return 8'h5A ^ (kk * 8'h3B);
  endfunction

  function automatic logic sbit(input int k, input int b);
    logic [7:0] v = sbyte(k);
    return v[b];
  endfunction

  // behavioural slave
  logic s_scl_p = 1'b1, s_sda_p = 1'b1;
  int sl_st = 0, sl_bits = 0, sl_k = 0;
  logic [7:0] sl_sh = '0;
  logic sl_rw = 1'b0, sl_mack = 1'b0;
  initial sl_drive = 1'b0;

  always @(posedge clk) begin
    s_scl_p <= scl_bus;
    s_sda_p <= sda_bus;
    if (rst) begin
      sl_st <= 0; sl_drive <= 1'b0;
    end else if (s_scl_p && scl_bus && s_sda_p && !sda_bus) begin
      sl_st <= 1; sl_bits <= 0; sl_drive <= 1'b0;
    end else if (s_scl_p && scl_bus && !s_sda_p && sda_bus) begin
      sl_st <= 0; sl_drive <= 1'b0;
    end else if (!s_scl_p && scl_bus) begin
      if (sl_st == 1) begin sl_sh <= {sl_sh[6:0], sda_bus}; sl_bits <= sl_bits + 1; end
      else if (sl_st == 3) sl_bits <= sl_bits + 1;
      else if (sl_st == 4) sl_mack <= !sda_bus;
    end else if (s_scl_p && !scl_bus) begin
      case (sl_st)
        1: if (sl_bits == 8) begin
             if (sl_sh[7:1] == SLV) begin sl_drive <= 1'b1; sl_st <= 2; sl_rw <= sl_sh[0]; end
             else sl_st <= 0;
           end
        2: if (sl_rw) begin
             sl_k <= 0; sl_bits <= 0; sl_drive <= !sbit(0, 7); sl_st <= 3;
           end else begin
             sl_drive <= 1'b0; sl_st <= 0;
           end
        3: if (sl_bits == 8) begin sl_drive <= 1'b0; sl_st <= 4; end
           else sl_drive <= !sbit(sl_k, 7 - sl_bits);
        4: if (sl_mack) begin
             sl_k <= sl_k + 1; sl_bits <= 0; sl_drive <= !sbit(sl_k + 1, 7); sl_st <= 3;
           end else begin
             sl_drive <= 1'b0; sl_st <= 0;
           end
        default: ;
      endcase
    end
  end

  // rival master pulling SDA low after a chosen SCL rise
  logic rival_on = 1'b0, rise_clr = 1'b0;
  int rival_target = 1, rise_cnt = 0;
  always @(posedge clk) begin
    if (rise_clr) rise_cnt <= 0;
    else if (!s_scl_p && scl_bus) rise_cnt <= rise_cnt + 1;
  end
  assign rival_low = rival_on && (rise_cnt >= rival_target);

  // per-clock shadow model of the hold and release rules
  always @(negedge clk) begin
    if (model_on && !rst) begin
      if (ctl_rdata[1] && status != 8'h38) chk("R11 scl held low while flag", scl_bus, 1'b0);
      if (status == 8'h38) chk("R9 lines released after loss", {scl_drive_low, sda_drive_low}, 2'b00);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wctl(input logic st, input logic sp, input logic fl, input logic ak);
    @(negedge clk);
    ctl_wdata = {st, sp, fl, ak}; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wdat(input logic [7:0] d);
    @(negedge clk);
    dat_wdata = d; dat_we = 1'b1;
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    int t = 0;
    while (!ctl_rdata[1] && t < 20000) begin @(negedge clk); t++; end
    if (t >= 20000) chk({req, " flag timeout"}, 0, 1);
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    while (status != 8'hF8 && t < 20000) begin @(negedge clk); t++; end
    if (t >= 20000) chk({req, " idle timeout"}, 0, 1);
  endtask

  task automatic arm_rival(input int target);
    @(negedge clk);
    rival_target = target; rise_clr = 1'b1;
    @(negedge clk);
    rise_clr = 1'b0; rival_on = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 status", status, 8'hF8);
    chk("R1 control bits", ctl_rdata, 4'h0);
    chk("R1 lines", {scl_drive_low, sda_drive_low}, 2'b00);
    model_on = 1'b1;

    wctl(1'b0, 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R11 write 1 to flag ignored", ctl_rdata[1], 1'b0);

    wctl(1'b1, 1'b0, 1'b1, 1'b0);
    wait_flag("R2");
    chk("R2 start status", status, 8'h08);

    wctl(1'b0, 1'b0, 1'b1, 1'b0);
    repeat (100) @(negedge clk);
    chk("R11 status frozen", status, 8'h08);
    chk("R11 flag kept", ctl_rdata[1], 1'b1);

    wdat(8'hA1);
    wctl(1'b0, 1'b0, 1'b0, 1'b1);
    wait_flag("R3");
    chk("R3 read address acked", status, 8'h40);

    wctl(1'b0, 1'b0, 1'b0, 1'b1);
    wait_flag("R4");
    chk("R4 ack status", status, 8'h50);
    chk("R4 byte 0", dat_rdata, sbyte(0));

    wctl(1'b0, 1'b0, 1'b0, 1'b0);
    wait_flag("R4");
    chk("R4 nack status", status, 8'h58);
    chk("R4 byte 1", dat_rdata, sbyte(1));

    wctl(1'b1, 1'b0, 1'b0, 1'b0);
    wait_flag("R5");
    chk("R5 repeated start from 58h", status, 8'h10);

    wdat(8'hB3);
    wctl(1'b0, 1'b0, 1'b0, 1'b0);
    wait_flag("R3");
    chk("R3 read address not acked", status, 8'h48);

    wctl(1'b0, 1'b1, 1'b0, 1'b0);
    wait_idle("R6");
    chk("R6 stop bit self-cleared", ctl_rdata[2], 1'b0);
    chk("R6 flag not set", ctl_rdata[1], 1'b0);
    repeat (3) @(negedge clk);
    chk("R6 lines released", {scl_bus, sda_bus}, 2'b11);

    wctl(1'b1, 1'b0, 1'b1, 1'b0);
    wait_flag("R2");
    chk("R2 second start", status, 8'h08);
    wdat(8'hA1);
    wctl(1'b0, 1'b0, 1'b0, 1'b0);
    wait_flag("R3");
    chk("R3 read address acked again", status, 8'h40);
    wctl(1'b0, 1'b0, 1'b0, 1'b0);
    wait_flag("R4");
    chk("R4 nack first byte", status, 8'h58);
    chk("R4 first byte value", dat_rdata, sbyte(0));

    wctl(1'b1, 1'b1, 1'b0, 1'b0);
    wait_flag("R7");
    chk("R7 stop then start", status, 8'h08);
    chk("R7 stop bit cleared", ctl_rdata[2], 1'b0);

    wdat(8'hA0);
    wctl(1'b0, 1'b0, 1'b0, 1'b0);
    wait_flag("R8");
    chk("R8 write address acked", status, 8'h18);

    wctl(1'b1, 1'b0, 1'b0, 1'b0);
    wait_flag("R5");
    chk("R5 repeated start from 18h", status, 8'h10);
    wdat(8'hB2);
    wctl(1'b0, 1'b0, 1'b0, 1'b0);
    wait_flag("R8");
    chk("R8 write address not acked", status, 8'h20);
    wctl(1'b0, 1'b1, 1'b0, 1'b0);
    wait_idle("R6");
    chk("R6 stop after 20h", status, 8'hF8);

    // arbitration loss in address, then release
    wctl(1'b1, 1'b0, 1'b1, 1'b0);
    wait_flag("R2");
    wdat(8'hA1);
    arm_rival(1);
    wctl(1'b0, 1'b0, 1'b0, 1'b0);
    wait_flag("R9");
    chk("R9 loss in address", status, 8'h38);
    chk("R9 lines released", {scl_drive_low, sda_drive_low}, 2'b00);
    wctl(1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 back to idle", status, 8'hF8);
    chk("R10 no flag", ctl_rdata[1], 1'b0);
    rival_on = 1'b0;
    repeat (60) @(negedge clk);
    chk("R10 stays idle", status, 8'hF8);

    // arbitration loss, then queued start
    wctl(1'b1, 1'b0, 1'b1, 1'b0);
    wait_flag("R2");
    wdat(8'hA1);
    arm_rival(1);
    wctl(1'b0, 1'b0, 1'b0, 1'b0);
    wait_flag("R9");
    chk("R9 loss again", status, 8'h38);
    wctl(1'b1, 1'b0, 1'b0, 1'b0);
    repeat (80) @(negedge clk);
    chk("R10 start waits for free bus", {ctl_rdata[1], status}, {1'b0, 8'hF8});
    rival_on = 1'b0;
    wait_flag("R10");
    chk("R10 queued start sent", status, 8'h08);

    // arbitration loss on the NACK bit
    wctl(1'b0, 1'b0, 1'b1, 1'b0);
    wctl(1'b0, 1'b0, 1'b0, 1'b0);
    wait_flag("R3");
    chk("R3 address acked before nack test", status, 8'h40);
    arm_rival(9);
    wctl(1'b0, 1'b0, 1'b0, 1'b0);
    wait_flag("R9");
    chk("R9 loss on nack bit", status, 8'h38);
    wctl(1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 idle after nack loss", status, 8'hF8);
    rival_on = 1'b0;
    repeat (60) @(negedge clk);

    model_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule